// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Victim Buffer

This block is a blocking data cache for a single in-order requester. A 4 KB direct-mapped array of 32-byte lines serves most accesses in one cycle. Lines pushed out of that array are kept in a four-entry fully associative victim buffer. When an access misses the array, the buffer is searched. If it holds the line, the two lines trade places at the cost of one extra cycle. If neither structure holds the line, it is fetched from memory as eight 4-byte beats after a fixed latency. In that case the line that gets displaced from the array is written into the least recently used victim entry.

The requester sees a ready/valid request channel and a one-cycle response pulse. Only one access is in flight at a time. Writes allocate in the cache and are also sent straight through to memory. The cache therefore never holds a line that differs from memory, and a line can leave the victim buffer without being written back. Three counters record the outcome of each access: array hit, victim hit, or memory fill.

Top module: `dmvc_cache`

## Requirements
- R1: An access accepted on a clock edge that hits the main array raises resp_valid in the first cycle after that edge. For a read, resp_rdata carries the stored 32-bit word selected by address bits [4:2].
- R2: An access that misses the main array but hits the victim buffer raises resp_valid in the second cycle after acceptance and issues no memory request.
- R3: After a victim hit, the requested line occupies the main-array slot and the next access to it is a one-cycle hit. The line it displaced moves into the freed victim entry and is found there as a victim hit.
- R4: An access that misses both structures pulses mem_req_valid for exactly one cycle, with mem_req_addr equal to address bits [31:5]. Memory answers with eight mem_rvalid beats in consecutive cycles, and beat k carries the word at byte offset 4k of the line. The first beat is sampled 41 edges after the edge that ends the request cycle, which models a 40-cycle latency plus 4 bytes per cycle. With this timing, resp_valid rises in the 50th cycle after acceptance.
- R5: A fill whose main-array slot holds a valid line moves that line into the victim buffer, where a later access finds it as a victim hit.
- R6: A fill with four valid victim entries replaces the entry written least recently. Both a fill and a victim-hit swap count as writing the entry they use.
- R7: Writes allocate with the same latency as reads. resp_rdata returns the written data. In the response cycle, mem_wr_valid pulses once with the full address and data, so memory always holds the latest value.
- R8: Each completed access increments exactly one of hit_count, victim_hit_count and miss_count, in the cycle in which resp_valid is high. Otherwise the counters hold their values.
- R9: Reset leaves req_ready high, resp_valid and mem_req_valid low, all counters at zero, and every main-array line and victim entry empty.
- R10: req_ready is low from the edge that accepts a missing access until the edge that completes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Cache can accept an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address (word aligned) |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Read data, or written data for a write |
| mem_req_valid | output | 1 | Line fetch request pulse |
| mem_req_addr | output | 27 | Line address of the fetch |
| mem_rvalid | input | 1 | Fill beat present |
| mem_rdata | input | 32 | Fill beat data |
| mem_wr_valid | output | 1 | Write-through pulse |
| mem_wr_addr | output | 32 | Write-through address |
| mem_wr_data | output | 32 | Write-through data |
| hit_count | output | 16 | Main-array hit count |
| victim_hit_count | output | 16 | Victim-buffer hit count |
| miss_count | output | 16 | Memory fill count |

## Verification
On the completing edge of a victim hit or a fill, the main-array slot and a victim entry are both written. The recency ages of all four victim entries are updated on that same edge. The bench provokes this with six lines that all map to one set, so every fill spills a line into the buffer. It then interleaves a victim-hit swap with further fills. The outcome is judged by latency alone: a line that is expected to have survived shows up as a two-cycle access, and a line that is expected to have been dropped costs the full 50 cycles. A write made through a victim hit is read back as a one-cycle hit, which confirms that the swapped line kept its merged data.

// File: rtl/dmvc_pkg.sv
package dmvc_pkg;
    localparam int ADDR_W      = 32;
    localparam int DATA_W      = 32;
    localparam int LINE_BYTES  = 32;
    localparam int CACHE_BYTES = 4096;
    localparam int VICT_N      = 4;

    localparam int WORDS   = LINE_BYTES / (DATA_W / 8);
    localparam int BOFF_W  = $clog2(DATA_W / 8);
    localparam int WSEL_W  = $clog2(WORDS);
    localparam int OFF_W   = $clog2(LINE_BYTES);
    localparam int SETS    = CACHE_BYTES / LINE_BYTES;
    localparam int IDX_W   = $clog2(SETS);
    localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
    localparam int LADDR_W = ADDR_W - OFF_W;
    localparam int LINE_W  = LINE_BYTES * 8;
    localparam int VIDX_W  = $clog2(VICT_N);

    typedef logic [LINE_W-1:0]  line_t;
    typedef logic [LADDR_W-1:0] laddr_t;

    typedef enum logic [1:0] {ST_IDLE, ST_PROBE, ST_FILL} state_e;
    typedef enum logic [1:0] {OC_NONE, OC_HIT, OC_VHIT, OC_MISS} outcome_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } req_t;

    typedef struct packed {
        logic   vld;
        laddr_t la;
        line_t  line;
    } vent_t;

    function automatic line_t put_word(line_t l, logic [WSEL_W-1:0] s, logic [DATA_W-1:0] w);
        line_t r;
        r = l;
        r[s*DATA_W +: DATA_W] = w;
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] get_word(line_t l, logic [WSEL_W-1:0] s);
        return l[s*DATA_W +: DATA_W];
    endfunction
endpackage

// File: rtl/dmvc_main_array.sv
module dmvc_main_array
    import dmvc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output line_t            rd_line,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  line_t            wr_line
);
    logic [SETS-1:0]  valid_q;
    logic [TAG_W-1:0] tag_q  [SETS];
    line_t            data_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_line;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_line  = data_q[rd_idx];
endmodule

// File: rtl/dmvc_victim_store.sv
module dmvc_victim_store
    import dmvc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  laddr_t            lk_la,
    output logic              lk_hit,
    output logic [VIDX_W-1:0] lk_way,
    output line_t             lk_line,
    output logic [VICT_N-1:0] lk_match,
    output logic [VIDX_W-1:0] lru_way,
    input  logic              wr_en,
    input  logic [VIDX_W-1:0] wr_way,
    input  logic              wr_valid,
    input  laddr_t            wr_la,
    input  line_t             wr_line
);
    vent_t             ent_q [VICT_N];
    logic [VIDX_W-1:0] age_q [VICT_N];

    for (genvar g = 0; g < VICT_N; g++) begin : g_ent
        assign lk_match[g] = ent_q[g].vld && (ent_q[g].la == lk_la);

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[g].vld <= 1'b0;
                age_q[g]     <= VIDX_W'(g);
            end else if (wr_en) begin
                if (wr_way == VIDX_W'(g)) begin
                    ent_q[g] <= '{vld: wr_valid, la: wr_la, line: wr_line};
                    age_q[g] <= '0;
                end else if (age_q[g] < age_q[wr_way]) begin
                    age_q[g] <= age_q[g] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        lk_way  = '0;
        lk_line = '0;
        lru_way = '0;
        for (int i = 0; i < VICT_N; i++) begin
            if (lk_match[i]) begin
                lk_way  = VIDX_W'(i);
                lk_line = ent_q[i].line;
            end
            if (age_q[i] == VIDX_W'(VICT_N - 1)) begin
                lru_way = VIDX_W'(i);
            end
        end
    end

    assign lk_hit = |lk_match;
endmodule

// File: rtl/dmvc_cache.sv
module dmvc_cache
    import dmvc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               resp_valid,
    output logic [DATA_W-1:0]  resp_rdata,
    output logic               mem_req_valid,
    output logic [LADDR_W-1:0] mem_req_addr,
    input  logic               mem_rvalid,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               mem_wr_valid,
    output logic [ADDR_W-1:0]  mem_wr_addr,
    output logic [DATA_W-1:0]  mem_wr_data,
    output logic [CNT_W-1:0]   hit_count,
    output logic [CNT_W-1:0]   victim_hit_count,
    output logic [CNT_W-1:0]   miss_count
);
    localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WORDS - 1);

    state_e             state_q;
    req_t               hold_q;
    logic [WSEL_W-1:0]  beat_q;
    line_t              fill_q;
    logic               resp_valid_q, mem_wr_valid_q;
    logic [DATA_W-1:0]  resp_rdata_q, mem_wr_data_q;
    logic [ADDR_W-1:0]  mem_wr_addr_q;
    logic [CNT_W-1:0]   hit_q, vhit_q, miss_q;

    logic               accept;
    logic [ADDR_W-1:0]  la_cur;
    logic               cur_wr;
    logic [DATA_W-1:0]  cur_wd;
    logic [IDX_W-1:0]   cur_idx;
    logic [TAG_W-1:0]   cur_tag;
    logic [WSEL_W-1:0]  cur_w;

    logic               m_valid, m_hit, m_we;
    logic [TAG_W-1:0]   m_tag;
    line_t              m_line;
    logic               v_hit, v_we;
    logic [VIDX_W-1:0]  v_hit_way, v_way, lru_way;
    line_t              v_line;
    logic [VICT_N-1:0]  v_match;

    logic               done;
    outcome_e           oc;
    line_t              src_line, new_line, fill_line;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign la_cur    = (state_q == ST_IDLE) ? req_addr  : hold_q.addr;
    assign cur_wr    = (state_q == ST_IDLE) ? req_write : hold_q.wr;
    assign cur_wd    = (state_q == ST_IDLE) ? req_wdata : hold_q.wdata;
    assign cur_idx   = la_cur[OFF_W +: IDX_W];
    assign cur_tag   = la_cur[ADDR_W-1 -: TAG_W];
    assign cur_w     = la_cur[BOFF_W +: WSEL_W];
    assign m_hit     = m_valid && (m_tag == cur_tag);
    assign fill_line = put_word(fill_q, LAST_BEAT, mem_rdata);

    dmvc_main_array u_main (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (cur_idx),
        .rd_valid(m_valid),
        .rd_tag  (m_tag),
        .rd_line (m_line),
        .wr_en   (m_we),
        .wr_idx  (cur_idx),
        .wr_tag  (cur_tag),
        .wr_line (new_line)
    );

    dmvc_victim_store u_vict (
        .clk     (clk),
        .rst     (rst),
        .lk_la   (hold_q.addr[ADDR_W-1:OFF_W]),
        .lk_hit  (v_hit),
        .lk_way  (v_hit_way),
        .lk_line (v_line),
        .lk_match(v_match),
        .lru_way (lru_way),
        .wr_en   (v_we),
        .wr_way  (v_way),
        .wr_valid(m_valid),
        .wr_la   ({m_tag, cur_idx}),
        .wr_line (m_line)
    );

    always_comb begin
        done     = 1'b0;
        oc       = OC_NONE;
        src_line = m_line;
        v_we     = 1'b0;
        v_way    = v_hit_way;
        unique case (state_q)
            ST_IDLE: if (accept && m_hit) begin
                done = 1'b1;
                oc   = OC_HIT;
            end
            ST_PROBE: if (v_hit) begin
                done     = 1'b1;
                oc       = OC_VHIT;
                src_line = v_line;
                v_we     = 1'b1;
            end
            ST_FILL: if (mem_rvalid && beat_q == LAST_BEAT) begin
                done     = 1'b1;
                oc       = OC_MISS;
                src_line = fill_line;
                v_we     = m_valid;
                v_way    = lru_way;
            end
            default: ;
        endcase
        new_line = cur_wr ? put_word(src_line, cur_w, cur_wd) : src_line;
        m_we     = done && ((state_q != ST_IDLE) || cur_wr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q        <= ST_IDLE;
            beat_q         <= '0;
            resp_valid_q   <= 1'b0;
            mem_wr_valid_q <= 1'b0;
            hit_q          <= '0;
            vhit_q         <= '0;
            miss_q         <= '0;
        end else begin
            resp_valid_q   <= done;
            mem_wr_valid_q <= done && cur_wr;
            unique case (state_q)
                ST_IDLE:  if (accept && !m_hit) state_q <= ST_PROBE;
                ST_PROBE: begin
                    beat_q  <= '0;
                    state_q <= v_hit ? ST_IDLE : ST_FILL;
                end
                ST_FILL: if (mem_rvalid) begin
                    beat_q <= beat_q + 1'b1;
                    if (beat_q == LAST_BEAT) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
            case (oc)
                OC_HIT:  hit_q  <= hit_q + CNT_W'(1);
                OC_VHIT: vhit_q <= vhit_q + CNT_W'(1);
                OC_MISS: miss_q <= miss_q + CNT_W'(1);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (accept) hold_q <= '{wr: req_write, addr: req_addr, wdata: req_wdata};
        if (state_q == ST_FILL && mem_rvalid) fill_q <= put_word(fill_q, beat_q, mem_rdata);
        if (done) begin
            resp_rdata_q  <= get_word(new_line, cur_w);
            mem_wr_addr_q <= la_cur;
            mem_wr_data_q <= cur_wd;
        end
    end

    assign resp_valid       = resp_valid_q;
    assign resp_rdata       = resp_rdata_q;
    assign mem_req_valid    = (state_q == ST_PROBE) && !v_hit;
    assign mem_req_addr     = hold_q.addr[ADDR_W-1:OFF_W];
    assign mem_wr_valid     = mem_wr_valid_q;
    assign mem_wr_addr      = mem_wr_addr_q;
    assign mem_wr_data      = mem_wr_data_q;
    assign hit_count        = hit_q;
    assign victim_hit_count = vhit_q;
    assign miss_count       = miss_q;
endmodule

// File: rtl/dmvc_cache_chk.sv
module dmvc_cache_chk
    import dmvc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              mem_req_valid,
    input logic              mem_wr_valid,
    input logic [CNT_W-1:0]  hit_count,
    input logic [CNT_W-1:0]  victim_hit_count,
    input logic [CNT_W-1:0]  miss_count,
    input logic              m_hit,
    input logic [VICT_N-1:0] v_match
);
    // R1: main-array hit completes one cycle after acceptance
    a_r1_hit_next: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && m_hit) |=> (resp_valid && hit_count == $past(hit_count) + CNT_W'(1)));

    // R2: a victim hit never has a memory request in its probe cycle
    a_r2_vhit_no_fetch: assert property (@(posedge clk) disable iff (rst)
        (victim_hit_count != $past(victim_hit_count)) |-> !$past(mem_req_valid));

    // R4: fetch request is a single-cycle pulse
    a_r4_req_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid);

    // R6: a line is never present twice in the victim buffer
    a_r6_unique_victim: assert property (@(posedge clk) disable iff (rst)
        $onehot0(v_match));

    // R7: write-through pulse coincides with a response
    a_r7_wt_with_resp: assert property (@(posedge clk) disable iff (rst)
        mem_wr_valid |-> resp_valid);

    // R8: exactly one counter moves with each response
    a_r8_one_outcome: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> ($countones({hit_count != $past(hit_count),
                                    victim_hit_count != $past(victim_hit_count),
                                    miss_count != $past(miss_count)}) == 1));

    // R8: counters hold without a response
    a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
        !resp_valid |-> (hit_count == $past(hit_count) &&
                         victim_hit_count == $past(victim_hit_count) &&
                         miss_count == $past(miss_count)));

    // R10: a response only appears once the block is ready again
    a_r10_resp_idle: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> req_ready);
endmodule

bind dmvc_cache dmvc_cache_chk #(.CNT_W(CNT_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .resp_valid      (resp_valid),
    .mem_req_valid   (mem_req_valid),
    .mem_wr_valid    (mem_wr_valid),
    .hit_count       (hit_count),
    .victim_hit_count(victim_hit_count),
    .miss_count      (miss_count),
    .m_hit           (m_hit),
    .v_match         (v_match)
);

// File: tb/dmvc_cache_tb.sv
module dmvc_cache_tb;
    logic        clk, rst;
    logic        req_valid, req_ready, req_write;
    logic [31:0] req_addr, req_wdata;
    logic        resp_valid;
    logic [31:0] resp_rdata;
    logic        mem_req_valid;
    logic [26:0] mem_req_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        mem_wr_valid;
    logic [31:0] mem_wr_addr, mem_wr_data;
    logic [15:0] hit_count, victim_hit_count, miss_count;

    dmvc_cache u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .hit_count(hit_count), .victim_hit_count(victim_hit_count), .miss_count(miss_count)
    );

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [7:0]  lat;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 18;
    // Six lines (tags 0..5) share set 0; replacement order traced by hand.
    localparam vec_t VEC [NV] = '{
        '{1'b0, 32'h0000_0000, 32'h0,          8'd50, 8'd4},  // R4 cold miss
        '{1'b0, 32'h0000_0004, 32'h0,          8'd1,  8'd1},  // R1 hit
        '{1'b1, 32'h0000_0008, 32'h1111_2222,  8'd1,  8'd7},  // R7 write hit
        '{1'b0, 32'h0000_0008, 32'h0,          8'd1,  8'd1},  // R1 read back
        '{1'b0, 32'h0000_1000, 32'h0,          8'd50, 8'd4},  // R4 evicts line 0
        '{1'b0, 32'h0000_2000, 32'h0,          8'd50, 8'd5},  // R5
        '{1'b0, 32'h0000_3000, 32'h0,          8'd50, 8'd5},  // R5
        '{1'b0, 32'h0000_4000, 32'h0,          8'd50, 8'd5},  // R5 buffer now full
        '{1'b0, 32'h0000_5000, 32'h0,          8'd50, 8'd6},  // R6 drops line 0
        '{1'b0, 32'h0000_1004, 32'h0,          8'd2,  8'd2},  // R2 victim hit
        '{1'b0, 32'h0000_1008, 32'h0,          8'd1,  8'd3},  // R3 swapped in
        '{1'b0, 32'h0000_0008, 32'h0,          8'd50, 8'd6},  // R6 line 0 gone
        '{1'b0, 32'h0000_2000, 32'h0,          8'd50, 8'd6},  // R6 touch kept line 5
        '{1'b0, 32'h0000_4010, 32'h0,          8'd2,  8'd6},  // R6 line 4 survived
        '{1'b1, 32'h0000_500C, 32'hCAFE_0001,  8'd2,  8'd7},  // R7 write via swap
        '{1'b0, 32'h0000_500C, 32'h0,          8'd1,  8'd3},  // R3 merged line in array
        '{1'b0, 32'h0000_0020, 32'h0,          8'd50, 8'd4},  // R4 other set
        '{1'b0, 32'h0000_4000, 32'h0,          8'd2,  8'd3}   // R3 displaced line
    };

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [31:0] mem_img [logic [31:0]];
    logic [31:0] ref_img [logic [31:0]];
    bit          mbusy = 0;
    int          mcnt  = 0;
    logic [26:0] mla   = '0;
    int          n_req = 0;

    function automatic logic [31:0] pat(logic [31:0] a);
        return (a & ~32'h3) ^ 32'hC3C3_0000;
    endfunction

    function automatic logic [31:0] mem_word(logic [31:0] a);
        return mem_img.exists(a) ? mem_img[a] : pat(a);
    endfunction

    function automatic logic [31:0] ref_word(logic [31:0] a);
        return ref_img.exists(a) ? ref_img[a] : pat(a);
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        clk = 0;
        forever #10 clk = ~clk;
    end

    // memory model: 40-cycle latency, then eight 4-byte beats
    initial begin
        mem_rvalid = 0;
        mem_rdata  = '0;
        forever begin
            @(negedge clk);
            if (mem_wr_valid) mem_img[mem_wr_addr & ~32'h3] = mem_wr_data;
            if (mbusy) begin
                mcnt++;
                if (mcnt >= 41 && mcnt <= 48) begin
                    mem_rvalid = 1;
                    mem_rdata  = mem_word({mla, 5'b0} + 32'(4 * (mcnt - 41)));
                end else begin
                    mem_rvalid = 0;
                end
                if (mcnt == 49) mbusy = 0;
            end else if (mem_req_valid) begin
                mbusy = 1;
                mcnt  = 0;
                mla   = mem_req_addr;
                n_req++;
            end
        end
    end

    task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] d,
                          output int lat, output logic [31:0] rd, output bit wt_ok);
        @(negedge clk);
        req_valid = 1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        lat = 1;
        if (!resp_valid) chk("R10 ready low while busy", 32'(req_ready), 32'd0);
        while (!resp_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        rd    = resp_rdata;
        wt_ok = wr ? (mem_wr_valid && mem_wr_addr == a && mem_wr_data == d) : !mem_wr_valid;
    endtask

    task automatic run_one(input string tag, input bit wr, input logic [31:0] a,
                           input logic [31:0] d, input int exp_lat);
        int          lat;
        logic [31:0] rd, exp_d;
        bit          wt_ok;
        int          nr0;
        exp_d = wr ? d : ref_word(a & ~32'h3);
        if (wr) ref_img[a & ~32'h3] = d;
        nr0 = n_req;
        access(wr, a, d, lat, rd, wt_ok);
        chk($sformatf("%s latency @%0h", tag, a), 32'(lat), 32'(exp_lat));
        chk($sformatf("%s data @%0h", tag, a), rd, exp_d);
        chk($sformatf("%s write-through R7 @%0h", tag, a), 32'(wt_ok), 32'd1);
        chk($sformatf("%s fetch count R2/R4 @%0h", tag, a), 32'(n_req - nr0),
            32'(exp_lat == 50 ? 1 : 0));
        if (exp_lat == 50) chk($sformatf("%s R4 line address", tag), 32'(mla), 32'(a[31:5]));
    endtask

    initial begin
        int e_hit = 0;
        int e_vh  = 0;
        int e_ms  = 0;
        rst = 1; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R9 ready after reset", 32'(req_ready), 32'd1);
        chk("R9 no response after reset", 32'(resp_valid), 32'd0);
        chk("R9 no fetch after reset", 32'(mem_req_valid), 32'd0);
        chk("R9 counters zero", 32'(hit_count) + 32'(victim_hit_count) + 32'(miss_count), 32'd0);

        for (int i = 0; i < NV; i++) begin
            run_one($sformatf("R%0d vec%0d", VEC[i].rq, i), VEC[i].wr, VEC[i].addr,
                    VEC[i].wdata, int'(VEC[i].lat));
            if (VEC[i].lat == 8'd1) e_hit++;
            else if (VEC[i].lat == 8'd2) e_vh++;
            else e_ms++;
        end
        chk("R8 hit count", 32'(hit_count), 32'(e_hit));
        chk("R8 victim hit count", 32'(victim_hit_count), 32'(e_vh));
        chk("R8 miss count", 32'(miss_count), 32'(e_ms));

        // R9: reset mid-run empties both structures and clears counters
        @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R9 counters cleared", 32'(hit_count) + 32'(victim_hit_count) + 32'(miss_count), 32'd0);
        chk("R9 ready after second reset", 32'(req_ready), 32'd1);
        run_one("R9 array emptied", 1'b0, 32'h0000_500C, 32'h0, 50);
        run_one("R9 victim emptied", 1'b0, 32'h0000_4000, 32'h0, 50);
        run_one("R1 hit after refill", 1'b0, 32'h0000_4004, 32'h0, 1);
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        summary();
    end
endmodule